// File: doc/BRIEF.md
# Pipelined Packed Complex Multiplier

This block multiplies two complex fixed-point numbers. Each operand arrives on one bus that holds the real part in its lower half and the imaginary part in its upper half. The result uses the same packing. A module parameter interprets operand parts as two's-complement or as unsigned. The result parts are always two's-complement, because the real part of a product of unsigned operands can still be negative. The result fraction position is the sum of the two operand fraction positions, so the fixed-point scaling needs no shifting inside the block.

A compile-time parameter selects the datapath. The direct form uses four real multipliers. The three-multiplier form adds pre-adders in front of the multipliers and extra post-additions behind them. Both forms use the same three-stage pipeline and produce identical bits. A valid flag moves with the data. An optional enable freezes every stage at once, and a synchronous reset empties the pipeline.

Top module: `cmul_packed`

## Requirements
- R1: Operand and result buses carry the real part in the low half and the imaginary part in the high half: op_a = {b, a} and op_b = {d, c} stand for a + jb and c + jd, and result = {imag, real}.
- R2: With real = a*c - b*d and imag = a*d + b*c, each result part is the exact value in OUT_W = 2*W+2 bits of two's-complement. Its fraction bit count is twice the operand fraction bit count.
- R3: The four-multiplier form and the three-multiplier form give bit-identical results and valid flags for the same input sequence.
- R4: The result and out_vld for the inputs sampled at an enabled rising edge appear after the third enabled edge. With en held high, that is three cycles later.
- R5: While en is low (HAS_EN = 1), no pipeline stage changes: out_vld and result hold their values, and processing resumes without loss when en returns high.
- R6: A rising edge with rst high clears out_vld and result to zero and drops any operands that are still in the pipeline.
- R7: In signed mode, extreme operands (most negative, most positive, -1, 0, 1 in any part) give the exact product with no overflow.
- R8: In unsigned mode (IS_SIGNED = 0), operand parts are zero-extended. A real part that is mathematically negative still appears correctly as a two's-complement value.
- R9: An input sampled with in_vld low produces out_vld low in its output slot. The datapath still computes its product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Pipeline advance; ignored when HAS_EN = 0 |
| in_vld | input | 1 | Operands on op_a/op_b are valid |
| op_a | input | 2*W | First operand {imag, real} |
| op_b | input | 2*W | Second operand {imag, real} |
| out_vld | output | 1 | result holds a product of valid operands |
| result | output | 2*(2*W+2) | Product {imag, real}, two's complement |

## Verification
The bound properties assume that rst is high at the first rising edge. They also assume that en and in_vld are always 0 or 1, never unknown. The stimulus holds reset from time zero and drives both controls only from the bench. The range property on result parts assumes signed mode. Operand values are never restricted there, since the chosen result width holds every signed product. The bench drives the same sequence into a signed direct instance, a signed three-multiplier instance and an unsigned three-multiplier instance. This covers extreme values, random patterns, enable gaps, invalid slots and a reset in mid-stream.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

    // Datapath structure selector
    typedef enum logic {
        CMUL_DIRECT    = 1'b0,
        CMUL_KARATSUBA = 1'b1
    } cmul_form_e;

    // Number of real multipliers the chosen structure needs
    function automatic int unsigned mul_count(cmul_form_e form);
        return (form == CMUL_KARATSUBA) ? 3 : 4;
    endfunction

    // Width of each result part for an operand part of w bits
    function automatic int unsigned part_out_width(int unsigned w);
        return 2 * w + 2;
    endfunction

endpackage

// File: rtl/cmul_prep.sv
// Stage 1: widen operand parts and form multiplier input pairs.
module cmul_prep #(
    parameter int unsigned         W         = 16,
    parameter bit                  IS_SIGNED = 1'b1,
    parameter cmul_pkg::cmul_form_e FORM     = cmul_pkg::CMUL_DIRECT,
    localparam int unsigned        NM        = cmul_pkg::mul_count(FORM),
    localparam int unsigned        OPW       = W + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    in_vld,
    input  logic [2*W-1:0]          op_a,
    input  logic [2*W-1:0]          op_b,
    output logic                    vld_o,
    output logic [NM-1:0][OPW-1:0]  lhs_o,
    output logic [NM-1:0][OPW-1:0]  rhs_o
);

    typedef struct packed {
        logic                   vld;
        logic [NM-1:0][OPW-1:0] lhs;
        logic [NM-1:0][OPW-1:0] rhs;
    } prep_t;

    prep_t s_d, s_q;

    function automatic logic [OPW-1:0] widen(input logic [W-1:0] v);
        return {{(OPW - W){IS_SIGNED & v[W-1]}}, v};
    endfunction

    logic [OPW-1:0] a_x, b_x, c_x, d_x;

    assign a_x = widen(op_a[W-1:0]);
    assign b_x = widen(op_a[2*W-1:W]);
    assign c_x = widen(op_b[W-1:0]);
    assign d_x = widen(op_b[2*W-1:W]);

    generate
        if (FORM == cmul_pkg::CMUL_KARATSUBA) begin : g_kara
            always_comb begin
                s_d = s_q;
                if (en) begin
                    s_d.vld    = in_vld;
                    s_d.lhs[0] = c_x;          // k1 = c * (a + b)
                    s_d.rhs[0] = a_x + b_x;
                    s_d.lhs[1] = a_x;          // k2 = a * (d - c)
                    s_d.rhs[1] = d_x - c_x;
                    s_d.lhs[2] = b_x;          // k3 = b * (c + d)
                    s_d.rhs[2] = c_x + d_x;
                end
            end
        end else begin : g_direct
            always_comb begin
                s_d = s_q;
                if (en) begin
                    s_d.vld    = in_vld;
                    s_d.lhs[0] = a_x;  s_d.rhs[0] = c_x;
                    s_d.lhs[1] = b_x;  s_d.rhs[1] = d_x;
                    s_d.lhs[2] = a_x;  s_d.rhs[2] = d_x;
                    s_d.lhs[3] = b_x;  s_d.rhs[3] = c_x;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign vld_o = s_q.vld;
    assign lhs_o = s_q.lhs;
    assign rhs_o = s_q.rhs;

endmodule

// File: rtl/cmul_mult.sv
// Stage 2: the real multipliers, one per operand pair.
module cmul_mult #(
    parameter int unsigned  OPW = 18,
    parameter int unsigned  NM  = 4,
    localparam int unsigned PW  = 2 * OPW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    vld_i,
    input  logic [NM-1:0][OPW-1:0]  lhs_i,
    input  logic [NM-1:0][OPW-1:0]  rhs_i,
    output logic                    vld_o,
    output logic [NM-1:0][PW-1:0]   prod_o
);

    typedef struct packed {
        logic                  vld;
        logic [NM-1:0][PW-1:0] prod;
    } mult_t;

    mult_t s_d, s_q;
    logic [NM-1:0][PW-1:0] prod_c;

    generate
        for (genvar i = 0; i < NM; i++) begin : g_mul
            logic signed [PW-1:0] l_x, r_x;
            assign l_x       = PW'($signed(lhs_i[i]));
            assign r_x       = PW'($signed(rhs_i[i]));
            assign prod_c[i] = l_x * r_x;
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        if (en) begin
            s_d.vld  = vld_i;
            s_d.prod = prod_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign vld_o  = s_q.vld;
    assign prod_o = s_q.prod;

endmodule

// File: rtl/cmul_sum.sv
// Stage 3: combine real products into the real and imaginary parts.
module cmul_sum #(
    parameter int unsigned          PW    = 36,
    parameter int unsigned          OUT_W = 34,
    parameter cmul_pkg::cmul_form_e FORM  = cmul_pkg::CMUL_DIRECT,
    localparam int unsigned         NM    = cmul_pkg::mul_count(FORM)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic                   vld_i,
    input  logic [NM-1:0][PW-1:0]  prod_i,
    output logic                   vld_o,
    output logic [OUT_W-1:0]       re_o,
    output logic [OUT_W-1:0]       im_o
);

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] re;
        logic [OUT_W-1:0] im;
    } sum_t;

    sum_t s_d, s_q;
    logic [PW-1:0] re_c, im_c;

    generate
        if (FORM == cmul_pkg::CMUL_KARATSUBA) begin : g_kara
            assign re_c = prod_i[0] - prod_i[2];   // k1 - k3
            assign im_c = prod_i[0] + prod_i[1];   // k1 + k2
        end else begin : g_direct
            assign re_c = prod_i[0] - prod_i[1];   // ac - bd
            assign im_c = prod_i[2] + prod_i[3];   // ad + bc
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        if (en) begin
            s_d.vld = vld_i;
            s_d.re  = re_c[OUT_W-1:0];
            s_d.im  = im_c[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign vld_o = s_q.vld;
    assign re_o  = s_q.re;
    assign im_o  = s_q.im;

endmodule

// File: rtl/cmul_packed.sv
module cmul_packed #(
    parameter int unsigned          W         = 16,
    parameter int unsigned          IN_FRAC   = 8,
    parameter bit                   IS_SIGNED = 1'b1,
    parameter bit                   HAS_EN    = 1'b1,
    parameter cmul_pkg::cmul_form_e FORM      = cmul_pkg::CMUL_DIRECT,
    localparam int unsigned         OUT_W     = cmul_pkg::part_out_width(W)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 in_vld,
    input  logic [2*W-1:0]       op_a,
    input  logic [2*W-1:0]       op_b,
    output logic                 out_vld,
    output logic [2*OUT_W-1:0]   result
);

    localparam int unsigned NM  = cmul_pkg::mul_count(FORM);
    localparam int unsigned OPW = W + 2;
    localparam int unsigned PW  = 2 * OPW;

    generate
        if (IN_FRAC > W) begin : g_bad_frac
            $error("cmul_packed: IN_FRAC exceeds W");
        end
    endgenerate

    logic en_eff;
    generate
        if (HAS_EN) begin : g_en
            assign en_eff = en;
        end else begin : g_no_en
            assign en_eff = 1'b1;
        end
    endgenerate

    logic                   s1_vld, s2_vld;
    logic [NM-1:0][OPW-1:0] s1_lhs, s1_rhs;
    logic [NM-1:0][PW-1:0]  s2_prod;
    logic [OUT_W-1:0]       res_re, res_im;

    cmul_prep #(.W(W), .IS_SIGNED(IS_SIGNED), .FORM(FORM)) u_prep (
        .clk(clk), .rst(rst), .en(en_eff), .in_vld(in_vld),
        .op_a(op_a), .op_b(op_b),
        .vld_o(s1_vld), .lhs_o(s1_lhs), .rhs_o(s1_rhs)
    );

    cmul_mult #(.OPW(OPW), .NM(NM)) u_mult (
        .clk(clk), .rst(rst), .en(en_eff), .vld_i(s1_vld),
        .lhs_i(s1_lhs), .rhs_i(s1_rhs),
        .vld_o(s2_vld), .prod_o(s2_prod)
    );

    cmul_sum #(.PW(PW), .OUT_W(OUT_W), .FORM(FORM)) u_sum (
        .clk(clk), .rst(rst), .en(en_eff), .vld_i(s2_vld),
        .prod_i(s2_prod),
        .vld_o(out_vld), .re_o(res_re), .im_o(res_im)
    );

    assign result = {res_im, res_re};

endmodule

// File: rtl/cmul_packed_chk.sv
module cmul_packed_chk #(
    parameter int unsigned W         = 16,
    parameter bit          IS_SIGNED = 1'b1,
    parameter bit          HAS_EN    = 1'b1,
    localparam int unsigned OUT_W    = 2 * W + 2
) (
    input logic               clk,
    input logic               rst,
    input logic               en,
    input logic               in_vld,
    input logic               out_vld,
    input logic [2*OUT_W-1:0] result
);

    // Edges seen since reset was released, saturating at 3
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R4 / R9: valid emerges three enabled edges after it entered
    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        ((since_rst == 2'd3) &&
         (!HAS_EN || ($past(en, 1) && $past(en, 2) && $past(en, 3))))
        |-> (out_vld == $past(in_vld, 3)));

    // R5: a low enable freezes the output
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (HAS_EN && !en) |=> ($stable(out_vld) && $stable(result)));

    // R6: reset empties the pipeline
    a_r6_clear: assert property (@(posedge clk)
        rst |=> (!out_vld && (result == '0)));

    // R2 / R7: signed products always fit one bit inside each result part
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (IS_SIGNED && out_vld) |->
        ((result[OUT_W-1] == result[OUT_W-2]) &&
         (result[2*OUT_W-1] == result[2*OUT_W-2])));

endmodule

bind cmul_packed cmul_packed_chk #(
    .W(W), .IS_SIGNED(IS_SIGNED), .HAS_EN(HAS_EN)
) u_chk (
    .clk(clk), .rst(rst), .en(en), .in_vld(in_vld),
    .out_vld(out_vld), .result(result)
);

// File: tb/cmul_packed_test.sv
module cmul_packed_test;

    localparam int W  = 16;
    localparam int OW = 2 * W + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b1;
    logic in_vld = 1'b0;
    logic [2*W-1:0] op_a = '0;
    logic [2*W-1:0] op_b = '0;

    logic vld_s, vld_k, vld_u;
    logic [2*OW-1:0] res_s, res_k, res_u;

    always #10 clk = ~clk;   // 50 MHz

    cmul_packed #(.W(W), .IS_SIGNED(1'b1), .FORM(cmul_pkg::CMUL_DIRECT)) uut (
        .clk(clk), .rst(rst), .en(en), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
        .out_vld(vld_s), .result(res_s));

    cmul_packed #(.W(W), .IS_SIGNED(1'b1), .FORM(cmul_pkg::CMUL_KARATSUBA)) uut_k (
        .clk(clk), .rst(rst), .en(en), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
        .out_vld(vld_k), .result(res_k));

    cmul_packed #(.W(W), .IS_SIGNED(1'b0), .FORM(cmul_pkg::CMUL_KARATSUBA)) uut_u (
        .clk(clk), .rst(rst), .en(en), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
        .out_vld(vld_u), .result(res_u));

    int n_chk = 0;
    int n_bad = 0;
    bit checking = 1'b0;
    bit done = 1'b0;
    string tag = "R6";

    // Behavioural reference: exact complex product in wide integers
    function automatic logic [2*OW-1:0] ref_mul(input logic [2*W-1:0] x,
                                                input logic [2*W-1:0] y,
                                                input bit sgn);
        longint ar, ai, br, bi, re, im;
        if (sgn) begin
            ar = longint'($signed(x[W-1:0]));   ai = longint'($signed(x[2*W-1:W]));
            br = longint'($signed(y[W-1:0]));   bi = longint'($signed(y[2*W-1:W]));
        end else begin
            ar = longint'(x[W-1:0]);            ai = longint'(x[2*W-1:W]);
            br = longint'(y[W-1:0]);            bi = longint'(y[2*W-1:W]);
        end
        re = ar * br - ai * bi;
        im = ar * bi + ai * br;
        return {im[OW-1:0], re[OW-1:0]};
    endfunction

    // Three-deep expected pipeline, shifted only on enabled edges
    logic [2*OW-1:0] exp_s[3];
    logic [2*OW-1:0] exp_u[3];
    logic            exp_v[3];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 3; i++) begin
                exp_s[i] = '0; exp_u[i] = '0; exp_v[i] = 1'b0;
            end
        end else if (en) begin
            exp_s[2] = exp_s[1]; exp_s[1] = exp_s[0];
            exp_u[2] = exp_u[1]; exp_u[1] = exp_u[0];
            exp_v[2] = exp_v[1]; exp_v[1] = exp_v[0];
            exp_s[0] = ref_mul(op_a, op_b, 1'b1);
            exp_u[0] = ref_mul(op_a, op_b, 1'b0);
            exp_v[0] = in_vld;
        end
    end

    task automatic check(input string req, input string who,
                         input logic av, input logic [2*OW-1:0] ad,
                         input logic ev, input logic [2*OW-1:0] ed);
        n_chk++;
        if (av !== ev || ad !== ed) begin
            n_bad++;
            $display("FAIL %s %s: actual vld=%b data=%h expected vld=%b data=%h",
                     req, who, av, ad, ev, ed);
        end
    endtask

    always @(negedge clk) begin
        if (checking) begin
            check(tag,  "uut",   vld_s, res_s, exp_v[2], exp_s[2]);
            check(tag,  "uut_k", vld_k, res_k, exp_v[2], exp_s[2]);
            check("R8", "uut_u", vld_u, res_u, exp_v[2], exp_u[2]);
            check("R3", "uut_k vs uut", vld_k, res_k, vld_s, res_s);
        end
    end

    task automatic drive(input logic [2*W-1:0] a, input logic [2*W-1:0] b, input logic v);
        op_a   = a;
        op_b   = b;
        in_vld = v;
        @(negedge clk);
    endtask

    function automatic logic [W-1:0] corner(input int k);
        case (k)
            0: return 16'h8000;   // most negative
            1: return 16'h7FFF;   // most positive
            2: return 16'hFFFF;   // -1
            3: return 16'h0000;
            default: return 16'h0001;
        endcase
    endfunction

    initial begin
        // R6: reset state
        tag = "R6";
        rst = 1'b1;
        @(negedge clk);
        checking = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: packing of real and imaginary halves
        tag = "R1";
        drive({16'd0, 16'd5}, {16'd0, 16'd7}, 1'b1);      // 5 * 7 = 35
        drive({16'd3, 16'd0}, {16'd4, 16'd0}, 1'b1);      // 3j * 4j = -12
        drive({16'd0, 16'd2}, {16'd9, 16'd0}, 1'b1);      // 2 * 9j = 18j
        drive({16'd6, 16'd0}, {16'd0, 16'd5}, 1'b1);      // 6j * 5 = 30j
        repeat (4) drive('0, '0, 1'b0);

        // R7: every combination of corner values in all four parts
        tag = "R7";
        for (int i0 = 0; i0 < 5; i0++)
            for (int i1 = 0; i1 < 5; i1++)
                for (int i2 = 0; i2 < 5; i2++)
                    for (int i3 = 0; i3 < 5; i3++)
                        drive({corner(i1), corner(i0)}, {corner(i3), corner(i2)}, 1'b1);

        // R2: random operands
        tag = "R2";
        for (int n = 0; n < 300; n++)
            drive($urandom, $urandom, 1'b1);

        // R4: an isolated valid pulse
        tag = "R4";
        drive(32'h0003_FFFE, 32'h7FFF_0004, 1'b1);
        repeat (5) drive($urandom, $urandom, 1'b0);

        // R9: invalid slots mixed with valid ones
        tag = "R9";
        for (int n = 0; n < 40; n++)
            drive($urandom, $urandom, 1'($urandom % 2));

        // R5: enable gaps
        tag = "R5";
        for (int n = 0; n < 200; n++) begin
            en = 1'($urandom % 3 != 0);
            drive($urandom, $urandom, 1'($urandom % 2));
        end
        en = 1'b0;
        repeat (6) drive($urandom, $urandom, 1'b1);
        en = 1'b1;
        repeat (4) drive($urandom, $urandom, 1'b1);

        // R6: reset in the middle of a stream
        tag = "R6";
        repeat (2) drive($urandom, $urandom, 1'b1);
        rst = 1'b1;
        repeat (2) drive($urandom, $urandom, 1'b1);
        rst = 1'b0;
        repeat (6) drive($urandom, $urandom, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL R4 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule